// File: doc/BRIEF.md
# Multi-Latency In-Order Issue Controller

This block is the issue-stage gatekeeper for an in-order pipeline whose execute stage holds four functional units: a single-cycle integer path, a pipelined adder, a pipelined multiplier, and a divider that is not pipelined. Each cycle at most one instruction is offered. It carries a unit selector, a destination register with a write enable, and two source registers, each with its own use flag. The controller works out in the same cycle whether the offer may issue. If it may not, it raises `stall`. The offering stage then holds the same instruction, so every younger instruction waits behind it.

The unit latencies differ, so results can finish out of program order. The controller keeps a countdown for each register with a write in flight. It stalls an offer on any of four conditions: a source still awaits its producer, the destination already has a write in flight, the new result would reach the single write-back port on the same edge as an older one, or the divider is still occupied. For each retiring write the block reports a registered write-back event with the register number.

Top module: `mlat_issue_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all in-flight state. After reset `wb_valid` is 0, and the first offered instruction issues without a stall.
- R2: An instruction that writes a register and is accepted at clock edge E produces `wb_valid`=1 with `wb_reg` equal to its destination after edge E+L. L is 1 for the integer unit (`unit`=0), 4 for the adder (`unit`=1), 7 for the multiplier (`unit`=2) and 24 for the divider (`unit`=3).
- R3: `stall` can only be 1 while `in_valid` is 1. An instruction is accepted on an edge where `in_valid`=1 and `stall`=0, and an offer held under stall produces no write-back until it is accepted.
- R4: An offer with an enabled source whose register has a write in flight stalls. The first cycle it may issue is the cycle in which `wb_valid` reports that register.
- R5: An offer whose enabled destination has a write in flight stalls until that write has been reported, so writes to one register retire in issue order.
- R6: At most one result is written back per cycle. An offer stalls if its result would retire on the same edge as a write already in flight.
- R7: The divider accepts one operation at a time. A divide offered right after another divide is accepted on the 24th edge after the first divide's issue edge, which is 23 stall cycles.
- R8: An instruction with `dst_wr`=0 produces no write-back, marks no register pending, and is never stalled by the destination or write-back port checks.
- R9: Registers are addressed by even numbers 0 to 30. Bit 0 of every register index is ignored, and `wb_reg` always reports an even number. Register 0 takes part in hazard checks like any other register.
- R10: `wb_valid` reports at most one register per cycle, and only a register that had a write in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Functional unit: 0 integer, 1 add, 2 multiply, 3 divide |
| in_dst | input | 5 | Destination register index (even) |
| in_dst_wr | input | 1 | The instruction writes its destination |
| in_src_a | input | 5 | First source register index |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | 5 | Second source register index |
| in_src_b_en | input | 1 | Second source is read |
| stall | output | 1 | The offered instruction may not issue this cycle |
| wb_valid | output | 1 | A result retires this cycle |
| wb_reg | output | 5 | Register index of the retiring result |

## Verification
The embedded assertions check four rules on every cycle: no instruction issues past a pending source or destination, only one register retires per edge, and no divide starts while the divider is busy. They also check that pending flags and countdowns always agree. Exact stall lengths can only be shown by the bench scenarios. So can exact write-back cycles, the aliasing of odd indices, and the absence of write-backs for non-writing instructions. The scoreboard compares these against timings worked out from the unit latencies.

// File: rtl/mlat_issue_pkg.sv
package mlat_issue_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/mlat_reg_track.sv
module mlat_reg_track #(
  parameter int NUM_REGS = 16,
  parameter int ENT_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             issue_i,
  input  logic                             wr_en_i,
  input  logic [ENT_W-1:0]                 dst_ent_i,
  input  logic [CNT_W-1:0]                 lat_i,
  input  logic                             src_a_en_i,
  input  logic [ENT_W-1:0]                 src_a_ent_i,
  input  logic                             src_b_en_i,
  input  logic [ENT_W-1:0]                 src_b_ent_i,
  output logic [NUM_REGS-1:0]              pend_o,
  output logic [NUM_REGS-1:0][CNT_W-1:0]   cnt_o,
  output logic                             wb_valid_o,
  output logic [ENT_W-1:0]                 wb_ent_o
);

  logic [NUM_REGS-1:0]            pend_q;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt_q;
  logic [NUM_REGS-1:0]            retire;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic claim;
    assign claim     = issue_i && wr_en_i && (dst_ent_i == ENT_W'(g));
    assign retire[g] = (cnt_q[g] == CNT_W'(1));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g]  <= '0;
        pend_q[g] <= 1'b0;
      end else if (claim) begin
        cnt_q[g]  <= lat_i;
        pend_q[g] <= 1'b1;
      end else if (cnt_q[g] != '0) begin
        cnt_q[g]  <= cnt_q[g] - CNT_W'(1);
        pend_q[g] <= (cnt_q[g] != CNT_W'(1));
      end
    end

    // R10: a pending flag always agrees with its countdown
    a_r10_flag_matches_count: assert property (@(posedge clk) disable iff (rst)
      pend_q[g] == (cnt_q[g] != '0));
  end

  logic             ret_any;
  logic [ENT_W-1:0] ret_ent;

  always_comb begin
    ret_any = 1'b0;
    ret_ent = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (retire[i] && !ret_any) begin
        ret_any = 1'b1;
        ret_ent = ENT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid_o <= 1'b0;
      wb_ent_o   <= '0;
    end else begin
      wb_valid_o <= ret_any;
      wb_ent_o   <= ret_ent;
    end
  end

  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

  // R10: never two registers retiring on one edge
  a_r10_single_retire: assert property (@(posedge clk) disable iff (rst)
    $onehot0(retire));

  // R4: no issue past a source still awaiting its producer
  a_r4_no_raw_issue: assert property (@(posedge clk) disable iff (rst)
    issue_i |-> !((src_a_en_i && pend_q[src_a_ent_i]) || (src_b_en_i && pend_q[src_b_ent_i])));

  // R5: no issue onto a destination with a write in flight
  a_r5_no_waw_issue: assert property (@(posedge clk) disable iff (rst)
    (issue_i && wr_en_i) |-> !pend_q[dst_ent_i]);

endmodule

// File: rtl/mlat_div_track.sv
module mlat_div_track #(
  parameter int LAT_DIV = 24,
  parameter int CNT_W   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o
);

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (start_i)       left_q <= CNT_W'(LAT_DIV);
    else if (left_q != '0)  left_q <= left_q - CNT_W'(1);
  end

  // the divider frees up on the edge its result retires
  assign busy_o = (left_q > CNT_W'(1));

  // R7: a new divide never starts while the previous one still needs the unit
  a_r7_div_exclusive: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (left_q <= CNT_W'(1)));

endmodule

// File: rtl/mlat_hazard.sv
module mlat_hazard
  import mlat_issue_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int ENT_W    = 4,
  parameter int CNT_W    = 5
) (
  input  logic                            valid_i,
  input  unit_e                           unit_i,
  input  logic                            wr_en_i,
  input  logic [ENT_W-1:0]                dst_ent_i,
  input  logic                            src_a_en_i,
  input  logic [ENT_W-1:0]                src_a_ent_i,
  input  logic                            src_b_en_i,
  input  logic [ENT_W-1:0]                src_b_ent_i,
  input  logic [CNT_W-1:0]                lat_i,
  input  logic [NUM_REGS-1:0]             pend_i,
  input  logic [NUM_REGS-1:0][CNT_W-1:0]  cnt_i,
  input  logic                            div_busy_i,
  output logic                            stall_o
);

  logic raw_hit, waw_hit, port_hit, div_hit;
  logic [CNT_W:0] slot;

  assign slot = {1'b0, lat_i} + (CNT_W+1)'(1);

  always_comb begin
    port_hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (pend_i[i] && ({1'b0, cnt_i[i]} == slot)) port_hit = 1'b1;
    end
    port_hit = port_hit && wr_en_i;
  end

  assign raw_hit = (src_a_en_i && pend_i[src_a_ent_i]) ||
                   (src_b_en_i && pend_i[src_b_ent_i]);
  assign waw_hit = wr_en_i && pend_i[dst_ent_i];
  assign div_hit = (unit_i == UNIT_DIV) && div_busy_i;

  assign stall_o = valid_i && (raw_hit || waw_hit || port_hit || div_hit);

endmodule

// File: rtl/mlat_issue_ctrl.sv
module mlat_issue_ctrl
  import mlat_issue_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int LAT_INT  = 1,
  parameter int LAT_ADD  = 4,
  parameter int LAT_MUL  = 7,
  parameter int LAT_DIV  = 24,
  localparam int ENT_W   = $clog2(NUM_REGS),
  localparam int IDX_W   = ENT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       in_unit,
  input  logic [IDX_W-1:0] in_dst,
  input  logic             in_dst_wr,
  input  logic [IDX_W-1:0] in_src_a,
  input  logic             in_src_a_en,
  input  logic [IDX_W-1:0] in_src_b,
  input  logic             in_src_b_en,
  output logic             stall,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_reg
);

  localparam int MAX_LAT = max_of4(LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV);
  localparam int CNT_W   = $clog2(MAX_LAT + 2);

  unit_e                          unit;
  logic [CNT_W-1:0]               lat;
  logic [ENT_W-1:0]               dst_ent, src_a_ent, src_b_ent, wb_ent;
  logic [NUM_REGS-1:0]            pend;
  logic [NUM_REGS-1:0][CNT_W-1:0] cnt;
  logic                           div_busy, issue, wb_v;

  assign unit      = unit_e'(in_unit);
  assign dst_ent   = in_dst[IDX_W-1:1];
  assign src_a_ent = in_src_a[IDX_W-1:1];
  assign src_b_ent = in_src_b[IDX_W-1:1];

  always_comb begin
    unique case (unit)
      UNIT_INT: lat = CNT_W'(LAT_INT);
      UNIT_ADD: lat = CNT_W'(LAT_ADD);
      UNIT_MUL: lat = CNT_W'(LAT_MUL);
      default:  lat = CNT_W'(LAT_DIV);
    endcase
  end

  mlat_hazard #(.NUM_REGS(NUM_REGS), .ENT_W(ENT_W), .CNT_W(CNT_W)) u_hazard (
    .valid_i     (in_valid),
    .unit_i      (unit),
    .wr_en_i     (in_dst_wr),
    .dst_ent_i   (dst_ent),
    .src_a_en_i  (in_src_a_en),
    .src_a_ent_i (src_a_ent),
    .src_b_en_i  (in_src_b_en),
    .src_b_ent_i (src_b_ent),
    .lat_i       (lat),
    .pend_i      (pend),
    .cnt_i       (cnt),
    .div_busy_i  (div_busy),
    .stall_o     (stall)
  );

  assign issue = in_valid && !stall;

  mlat_reg_track #(.NUM_REGS(NUM_REGS), .ENT_W(ENT_W), .CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .issue_i     (issue),
    .wr_en_i     (in_dst_wr),
    .dst_ent_i   (dst_ent),
    .lat_i       (lat),
    .src_a_en_i  (in_src_a_en),
    .src_a_ent_i (src_a_ent),
    .src_b_en_i  (in_src_b_en),
    .src_b_ent_i (src_b_ent),
    .pend_o      (pend),
    .cnt_o       (cnt),
    .wb_valid_o  (wb_v),
    .wb_ent_o    (wb_ent)
  );

  mlat_div_track #(.LAT_DIV(LAT_DIV), .CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (issue && (unit == UNIT_DIV)),
    .busy_o  (div_busy)
  );

  assign wb_valid = wb_v;
  assign wb_reg   = {wb_ent, 1'b0};

  // R3: stall is only ever raised against an offered instruction
  a_r3_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
    stall |-> in_valid);

endmodule

// File: tb/mlat_issue_ctrl_bench.sv
module mlat_issue_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic [4:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       in_dst_wr = 1'b0, in_src_a_en = 1'b0, in_src_b_en = 1'b0;
  logic       stall, wb_valid;
  logic [4:0] wb_reg;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  typedef struct { int due; logic [4:0] rg; string tag; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mlat_issue_ctrl u_mlat_issue_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_dst(in_dst), .in_dst_wr(in_dst_wr), .in_src_a(in_src_a),
    .in_src_a_en(in_src_a_en), .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
    .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg)
  );

  function automatic int lat_of(input logic [1:0] u);
    case (u)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 7;
      default: return 24;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares each cycle's write-back against the scoreboard
  always @(negedge clk) begin
    #2;
    if (!rst && !finished) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        check(wb_valid === 1'b1, {q[0].tag, " wb_valid"}, int'(wb_valid), 1);
        check(wb_reg === q[0].rg, {q[0].tag, " wb_reg"}, int'(wb_reg), int'(q[0].rg));
        void'(q.pop_front());
      end else if (wb_valid !== 1'b0) begin
        check(1'b0, "R10/R8 unexpected write-back", int'(wb_reg), -1);
      end
    end
  end

  // driver: called at a falling edge; offers, counts stalls, pushes expectation
  task automatic offer(input logic [1:0] u, input logic [4:0] d, input bit dw,
                       input logic [4:0] sa, input bit sae,
                       input logic [4:0] sb, input bit sbe,
                       input int exp_stall, input string tag);
    int n = 0;
    exp_t e;
    in_valid = 1; in_unit = u; in_dst = d; in_dst_wr = dw;
    in_src_a = sa; in_src_a_en = sae; in_src_b = sb; in_src_b_en = sbe;
    #1;
    while (stall === 1'b1) begin
      n++;
      @(negedge clk); #1;
    end
    check(n == exp_stall, {tag, " stall cycles"}, n, exp_stall);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (dw) begin
      int pos = q.size();
      e.due = cyc + lat_of(u);
      e.rg = {d[4:1], 1'b0};
      e.tag = tag;
      for (int i = 0; i < q.size(); i++)
        if (e.due < q[i].due) begin pos = i; break; end
      q.insert(pos, e);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: idle after reset
    check(wb_valid === 1'b0, "R1 wb_valid after reset", int'(wb_valid), 0);
    offer(2'd0, 5'd2, 1, 5'd0, 0, 5'd0, 0, 0, "R1 R2 int");
    drain();
    offer(2'd1, 5'd4, 1, 5'd0, 0, 5'd0, 0, 0, "R2 add");
    drain();
    offer(2'd2, 5'd6, 1, 5'd0, 0, 5'd0, 0, 0, "R2 mul");
    drain();
    // back-to-back independent ops, out-of-order completion
    offer(2'd2, 5'd4, 1, 5'd0, 0, 5'd0, 0, 0, "R2 mix mul");
    offer(2'd1, 5'd6, 1, 5'd0, 0, 5'd0, 0, 0, "R2 mix add");
    offer(2'd0, 5'd8, 1, 5'd0, 0, 5'd0, 0, 0, "R2 mix int");
    drain();
    // R4: consumer of a multiply result
    offer(2'd2, 5'd10, 1, 5'd0, 0, 5'd0, 0, 0, "R4 producer");
    offer(2'd0, 5'd12, 1, 5'd30, 1, 5'd10, 1, 7, "R4 consumer");
    drain();
    // R5: second write to the same register
    offer(2'd1, 5'd14, 1, 5'd0, 0, 5'd0, 0, 0, "R5 first");
    offer(2'd0, 5'd14, 1, 5'd0, 0, 5'd0, 0, 4, "R5 second");
    drain();
    // R6: write-back port collision
    offer(2'd2, 5'd16, 1, 5'd0, 0, 5'd0, 0, 0, "R6 mul");
    offer(2'd0, 5'd20, 1, 5'd0, 0, 5'd0, 0, 0, "R6 int a");
    offer(2'd0, 5'd22, 1, 5'd0, 0, 5'd0, 0, 0, "R6 int b");
    offer(2'd1, 5'd18, 1, 5'd0, 0, 5'd0, 0, 1, "R6 add");
    drain();
    // R7: back-to-back divides
    offer(2'd3, 5'd24, 1, 5'd0, 0, 5'd0, 0, 0, "R7 div a");
    offer(2'd3, 5'd26, 1, 5'd0, 0, 5'd0, 0, 23, "R7 div b");
    drain();
    // R8: no destination write
    offer(2'd2, 5'd28, 0, 5'd0, 0, 5'd0, 0, 0, "R8 mul nowrite");
    offer(2'd0, 5'd28, 1, 5'd28, 1, 5'd0, 0, 0, "R8 follower");
    drain();
    // R9: register 0 and odd alias
    offer(2'd1, 5'd0, 1, 5'd0, 0, 5'd0, 0, 0, "R9 add r0");
    offer(2'd0, 5'd2, 1, 5'd1, 1, 5'd0, 0, 4, "R9 odd alias");
    drain();
    // R3: no stall without an offer, even with a hazard on the inputs
    offer(2'd2, 5'd6, 1, 5'd0, 0, 5'd0, 0, 0, "R3 producer");
    in_valid = 0; in_src_a = 5'd6; in_src_a_en = 1; #1;
    check(stall === 1'b0, "R3 stall with in_valid low", int'(stall), 0);
    in_src_a_en = 0;
    drain();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule